// File: doc/BRIEF.md
# Two-Way Word Exchanger Between One Narrow Port and Two Half Ports

The block joins one 12-bit A side to two 12-bit B halves, named bank 1 and bank 2. From A towards B, each half has an edge-triggered register that loads the A word on a rising clock edge while its own active-low load control is asserted. Loading the two halves on successive edges places two consecutive A words side by side, so that the B side shows one 24-bit word {bank 2, bank 1}.

From B towards A, each half has a level-sensitive latch. The latch follows its B input while its active-low open control is low and keeps its value while that control is high, so this direction needs no clock. A route select picks which latch drives the A side. Each side has an active-low output enable. Pads are modelled as separate input, output and output-enable signals, and the surrounding logic resolves them onto tri-state nets. The data paths have no reset.

Top module: `wide_bus_exchanger`

## Requirements
- R1: `b_en_n` high drives `b1_oe` and `b2_oe` to 0, so both B halves are high-impedance. `b_en_n` low drives both to 1 together.
- R2: At a rising `clk` edge where `cap1_n` (or `cap2_n`) is low, the bank 1 (or bank 2) register loads `a_in`. The new value shows on `b1_out` (or `b2_out`) directly after that edge.
- R3: At a rising edge where a bank's load control is high, that bank keeps its value, whatever `a_in` carries.
- R4: The two banks load independently. Loading word X into bank 1 and then word Y into bank 2 on the next edge gives the 24-bit B word {Y, X}.
- R5: While `open1_n` (or `open2_n`) is low, that latch is transparent. With the latch routed to A, `a_out` follows `b1_in` (or `b2_in`) without any clock edge.
- R6: While a latch's open control is high, the latch holds its last value, and changes on its B input do not reach `a_out`.
- R7: `pick_b2` = 0 routes the bank 1 latch to `a_out`. `pick_b2` = 1 routes the bank 2 latch. Switching the select changes `a_out` without a clock.
- R8: `a_en_n` high drives `a_oe` to 0, so the A side is high-impedance. `a_en_n` low drives `a_oe` to 1.
- R9: Output enables change no stored state. After B is disabled and enabled again, each half shows its earlier register value, and the A side shows its earlier latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the A-to-B registers |
| a_in | input | 12 | A side input data |
| a_out | output | 12 | A side output data (selected latch) |
| a_oe | output | 1 | A side pad drive enable, active high |
| b1_in | input | 12 | Bank 1 input data |
| b1_out | output | 12 | Bank 1 register contents |
| b1_oe | output | 1 | Bank 1 pad drive enable, active high |
| b2_in | input | 12 | Bank 2 input data |
| b2_out | output | 12 | Bank 2 register contents |
| b2_oe | output | 1 | Bank 2 pad drive enable, active high |
| cap1_n | input | 1 | Bank 1 register load, active low |
| cap2_n | input | 1 | Bank 2 register load, active low |
| open1_n | input | 1 | Bank 1 latch transparent when low |
| open2_n | input | 1 | Bank 2 latch transparent when low |
| pick_b2 | input | 1 | Route select: 0 bank 1 latch, 1 bank 2 latch |
| a_en_n | input | 1 | A side output enable, active low |
| b_en_n | input | 1 | B side output enable, active low |

## Verification
The hardest case to reach from the ports is a latch holding a value while its B input has since changed and the other latch holds a different value. Only in that state can a wrong route or a leaky hold be told apart from correct behaviour. The stimulus fills the two latches with distinct words in separate open windows. It closes each latch, then drives new data onto the closed inputs. Only after that does it flip the select and toggle the A enable. Each open window spans a clock edge, so the clocked hold and transparency assertions sample every phase.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int unsigned BX_BANKS = 2;

  typedef enum logic {
    ROUTE_FIRST  = 1'b0,
    ROUTE_SECOND = 1'b1
  } route_e;
endpackage

// File: rtl/bx_capture_bank.sv
module bx_capture_bank #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         load_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         load_evt
);
  logic [W-1:0] q_r;

  assign load_evt = ~load_n;

  always_ff @(posedge clk) begin
    if (load_evt) q_r <= d;
  end

  assign q = q_r;

  // R2: an enabled edge captures the input seen at that edge
  assert_capture_R2: assert property (@(posedge clk)
    load_evt |=> (q == $past(d)));

  // R3: a disabled edge leaves the contents untouched
  assert_keep_R3: assert property (@(posedge clk)
    !load_evt |=> $stable(q));
endmodule

// File: rtl/bx_return_latch.sv
module bx_return_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         open_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         hold_evt
);
  logic [W-1:0] q_l;

  assign hold_evt = open_n;

  always_latch begin
    if (!open_n) q_l <= d;
  end

  assign q = q_l;

  // R5: an open latch shows its input
  assert_transparent_R5: assert property (@(posedge clk)
    !hold_evt |-> (q == d));

  // R6: a latch closed at two successive edges did not move
  assert_hold_R6: assert property (@(posedge clk)
    hold_evt |=> (hold_evt -> $stable(q)));
endmodule

// File: rtl/bx_out_gate.sv
module bx_out_gate #(
  parameter int unsigned W = 12
) (
  input  logic         en_n,
  input  logic [W-1:0] data,
  output logic [W-1:0] pad_out,
  output logic         pad_oe
);
  assign pad_oe  = ~en_n;
  assign pad_out = data;
endmodule

// File: rtl/wide_bus_exchanger.sv
module wide_bus_exchanger
  import bx_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         cap1_n,
  input  logic         cap2_n,
  input  logic         open1_n,
  input  logic         open2_n,
  input  logic         pick_b2,
  input  logic         a_en_n,
  input  logic         b_en_n
);
  localparam int unsigned WIDE_W = W * BX_BANKS;

  function automatic logic [W-1:0] route_word(route_e r, logic [W-1:0] w_first,
                                              logic [W-1:0] w_second);
    return (r == ROUTE_SECOND) ? w_second : w_first;
  endfunction

  logic [BX_BANKS-1:0][W-1:0] b_in_v, reg_q, lat_q, b_out_v;
  logic [BX_BANKS-1:0]        cap_n_v, open_n_v, b_oe_v, load_evt, hold_evt;
  logic [WIDE_W-1:0]          b_word;
  logic [W-1:0]               a_word;
  route_e                     route;

  assign b_in_v   = {b2_in, b1_in};
  assign cap_n_v  = {cap2_n, cap1_n};
  assign open_n_v = {open2_n, open1_n};
  assign route    = route_e'(pick_b2);

  for (genvar k = 0; k < BX_BANKS; k++) begin : g_bank
    bx_capture_bank #(.W(W)) u_cap (
      .clk(clk), .load_n(cap_n_v[k]), .d(a_in),
      .q(reg_q[k]), .load_evt(load_evt[k])
    );
    bx_return_latch #(.W(W)) u_lat (
      .clk(clk), .open_n(open_n_v[k]), .d(b_in_v[k]),
      .q(lat_q[k]), .hold_evt(hold_evt[k])
    );
    bx_out_gate #(.W(W)) u_bout (
      .en_n(b_en_n), .data(reg_q[k]),
      .pad_out(b_out_v[k]), .pad_oe(b_oe_v[k])
    );
  end

  assign b_word = b_out_v;
  assign a_word = route_word(route, lat_q[0], lat_q[1]);

  bx_out_gate #(.W(W)) u_aout (
    .en_n(a_en_n), .data(a_word), .pad_out(a_out), .pad_oe(a_oe)
  );

  assign b1_out = b_word[W-1:0];
  assign b2_out = b_word[WIDE_W-1:W];
  assign b1_oe  = b_oe_v[0];
  assign b2_oe  = b_oe_v[1];

  // R1: both B halves are enabled and disabled together
  assert_b_pair_R1: assert property (@(posedge clk) b1_oe == b2_oe);

  // R7: an open routed latch carries its own B input to A
  assert_route_first_R7: assert property (@(posedge clk)
    (!pick_b2 && !open1_n) |-> (a_out == b1_in));
  assert_route_second_R7: assert property (@(posedge clk)
    (pick_b2 && !open2_n) |-> (a_out == b2_in));
endmodule

// File: tb/test_wide_bus_exchanger.sv
module test_wide_bus_exchanger;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic         cap1_n = 1'b1, cap2_n = 1'b1, open1_n = 1'b1, open2_n = 1'b1;
  logic         pick_b2 = 1'b0, a_en_n = 1'b1, b_en_n = 1'b1;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wide_bus_exchanger #(.W(W)) i_wide_bus_exchanger (
    .clk(clk), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
    .cap1_n(cap1_n), .cap2_n(cap2_n), .open1_n(open1_n), .open2_n(open2_n),
    .pick_b2(pick_b2), .a_en_n(a_en_n), .b_en_n(b_en_n)
  );

  wire [W-1:0] a_pad  = a_oe  ? a_out  : 'z;
  wire [W-1:0] b1_pad = b1_oe ? b1_out : 'z;
  wire [W-1:0] b2_pad = b2_oe ? b2_out : 'z;

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset_state();
    #1;
    check("R8 A high-z at start", {12'h0, a_pad}, {12'h0, 12'bz});
    check("R1 B high-z at start", {b2_pad, b1_pad}, {12'bz, 12'bz});
  endtask

  task automatic t_capture();
    b_en_n = 1'b0;
    a_in = 12'h123; cap1_n = 1'b0; tick();
    check("R2 bank1 load", {12'h0, b1_pad}, {12'h0, 12'h123});
    check("R1 B both driving", {22'h0, b2_oe, b1_oe}, 24'h3);
    a_in = 12'hABC; cap1_n = 1'b1; cap2_n = 1'b0; tick();
    check("R4 wide word", {b2_pad, b1_pad}, {12'hABC, 12'h123});
    cap2_n = 1'b1;
  endtask

  task automatic t_hold();
    a_in = 12'hFFF;
    tick(); tick(); tick();
    check("R3 both banks keep", {b2_pad, b1_pad}, {12'hABC, 12'h123});
    a_in = 12'h555; cap1_n = 1'b0; cap2_n = 1'b0; tick();
    check("R2 both banks load", {b2_pad, b1_pad}, {12'h555, 12'h555});
    a_in = 12'h0F0; cap1_n = 1'b1; tick();
    check("R3 bank1 keeps, R2 bank2 loads", {b2_pad, b1_pad}, {12'h0F0, 12'h555});
    cap2_n = 1'b1;
  endtask

  task automatic t_latch();
    a_en_n = 1'b0; pick_b2 = 1'b0;
    b1_in = 12'h3C3; open1_n = 1'b0; #1;
    check("R5 bank1 transparent", {12'h0, a_pad}, {12'h0, 12'h3C3});
    b1_in = 12'h7E1; #1;
    check("R5 follows change", {12'h0, a_pad}, {12'h0, 12'h7E1});
    tick();
    open1_n = 1'b1; tick();
    b1_in = 12'h000; tick();
    check("R6 bank1 holds", {12'h0, a_pad}, {12'h0, 12'h7E1});
  endtask

  task automatic t_select();
    b2_in = 12'hA5A; open2_n = 1'b0; tick();
    check("R6 closed bank1 unaffected", {12'h0, a_pad}, {12'h0, 12'h7E1});
    open2_n = 1'b1; tick();
    b2_in = 12'h111; tick();
    pick_b2 = 1'b1; #1;
    check("R7 select bank2", {12'h0, a_pad}, {12'h0, 12'hA5A});
    pick_b2 = 1'b0; #1;
    check("R7 select bank1", {12'h0, a_pad}, {12'h0, 12'h7E1});
    tick();
  endtask

  task automatic t_enables();
    a_en_n = 1'b1; #1;
    check("R8 A disabled", {12'h0, a_pad}, {12'h0, 12'bz});
    b_en_n = 1'b1; tick();
    check("R1 B disabled", {b2_pad, b1_pad}, {12'bz, 12'bz});
    b_en_n = 1'b0; a_en_n = 1'b0; pick_b2 = 1'b1; #1;
    check("R9 B contents kept", {b2_pad, b1_pad}, {12'h0F0, 12'h555});
    check("R9 A latch kept", {12'h0, a_pad}, {12'h0, 12'hA5A});
    tick();
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    tick();
    t_capture();
    t_hold();
    t_latch();
    t_select();
    t_enables();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule